// File: doc/BRIEF.md
# Unsigned Subtract and Status Unit

This unit performs one unsigned 32-bit subtraction per execute strobe in a DSP datapath. It takes the current product-register value and a 32-bit operand, and registers the difference as the new register value. On the same clock edge it updates four status bits and a 6-bit unsigned-borrow counter:

- zero
- negative
- carry, which is the inverted borrow
- sticky signed overflow

It decodes the two-word instruction encoding. It also raises a one-cycle repeat-clear pulse when the instruction is issued while a repeat is pending, because the instruction always runs exactly once.

A companion high-word step subtracts with borrow, taking the borrow from the stored carry bit. Software uses it to build 64-bit differences. First it runs the unsigned low-word subtract. Then it requests the high-word step, which does not need the opcode match. Every output comes from a flop. A synchronous active-high reset clears all state.

Top module: `usub_flag_unit`

## Requirements
- R1: On a clock edge where `exec_i` is high and the opcode matches, `p_o` becomes `reg_i - operand_i` modulo 2^32.
- R2: After each executed subtract, `z_o` is 1 exactly when the 32-bit result is zero.
- R3: After each executed subtract, `n_o` equals bit 31 of the result.
- R4: After each executed subtract, `c_o` is 0 if the subtraction borrowed (minuend less than subtrahend plus borrow-in) and 1 otherwise.
- R5: `v_o` is set when an executed subtract has a signed overflow, and is otherwise left unchanged. A signed overflow means the operands' bit 31 differ and the result's bit 31 differs from the minuend's. Once set, `v_o` stays 1 until reset.
- R6: `ovcu_o` decrements by one, wrapping from 0 to 63, on every executed subtract that borrows. It holds otherwise. `ovm_i` has no effect on it.
- R7: When a subtract executes with `rpt_pending_i` high, `rpt_clear_o` is 1 for exactly the following cycle. The subtraction is applied once. When there is no pending repeat, `rpt_clear_o` is 0.
- R8: The opcode matches only when `op_word0_i` is 16'h565D and `op_word1_i[15:8]` is zero. On a match, `loc_o` captures `op_word1_i[7:0]`. With no match and `hi_step_i` low, the strobe changes no output.
- R9: When `hi_step_i` is high with `exec_i`, `p_o` becomes `reg_i - operand_i - (1 - c_o)`. Flags and counter follow R2 to R6, and `loc_o` is unchanged.
- R10: After synchronous reset, `p_o`, all four flags, `ovcu_o`, `rpt_clear_o` and `loc_o` are zero.
- R11: Every output changes only on the edge that samples the strobe, and holds its value on cycles without the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe |
| hi_step_i | input | 1 | Request the subtract-with-borrow high-word step |
| ovm_i | input | 1 | Overflow-mode bit (does not affect the counter) |
| rpt_pending_i | input | 1 | A repeat is pending for this instruction |
| op_word0_i | input | 16 | First instruction word |
| op_word1_i | input | 16 | Second instruction word |
| reg_i | input | 32 | Current register value (minuend) |
| operand_i | input | 32 | 32-bit memory operand (subtrahend) |
| p_o | output | 32 | New register value |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| c_o | output | 1 | Carry flag, inverted borrow |
| v_o | output | 1 | Sticky signed-overflow flag |
| ovcu_o | output | 6 | Unsigned-borrow counter |
| rpt_clear_o | output | 1 | Repeat-counter clear pulse |
| loc_o | output | 8 | Captured location field |

## Verification
A wrong borrow computation shows at the ports one cycle after the strobe in two places: `c_o` and `ovcu_o` disagree with a model of the borrow. Because the high-word step takes its borrow from `c_o`, the error also carries into the next chained result. A corrupted counter or a V bit that clears itself stays visible on every later cycle, since both only move on specific events. A decode fault shows as a change to `p_o` or `loc_o` after a strobe with a mismatched opcode, at the very next sample.

// File: rtl/usub_pkg.sv
package usub_pkg;
  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } usub_flags_t;

  localparam logic [15:0] USUB_HEAD_WORD = 16'h565D;
endpackage

// File: rtl/usub_decode.sv
module usub_decode #(
  parameter int               OP_W  = 16,
  parameter int               LOC_W = 8,
  parameter logic [OP_W-1:0]  HEAD  = usub_pkg::USUB_HEAD_WORD
) (
  input  logic [OP_W-1:0]  word0_i,
  input  logic [OP_W-1:0]  word1_i,
  output logic             hit_o,
  output logic [LOC_W-1:0] loc_o
);
  localparam int PAD_W = OP_W - LOC_W;

  logic head_ok;
  logic pad_ok;

  always_comb begin
    head_ok = (word0_i == HEAD);
    pad_ok  = (word1_i[OP_W-1:LOC_W] == {PAD_W{1'b0}});
    hit_o   = head_ok && pad_ok;
    loc_o   = word1_i[LOC_W-1:0];
  end
endmodule

// File: rtl/usub_alu.sv
module usub_alu #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              bin_i,
  output logic [DATA_W-1:0] diff_o,
  output logic              borrow_o,
  output logic              sovf_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;

  always_comb begin
    wide     = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, bin_i};
    diff_o   = wide[MSB:0];
    borrow_o = wide[DATA_W];
    sovf_o   = (a_i[MSB] != b_i[MSB]) && (wide[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/usub_ovcu.sv
module usub_ovcu #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_i,
  input  logic             ovm_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)        cnt_o <= '0;
    else if (dec_i) cnt_o <= cnt_o - ONE;
  end

  p_ovcu_dec_r6: assert property (@(posedge clk) disable iff (rst)
    dec_i |=> (cnt_o == $past(cnt_o) - ONE));

  p_ovcu_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!dec_i && (ovm_i || !ovm_i)) |=> $stable(cnt_o));
endmodule

// File: rtl/usub_flag_unit.sv
module usub_flag_unit #(
  parameter int              DATA_W = 32,
  parameter int              CNT_W  = 6,
  parameter int              OP_W   = 16,
  parameter int              LOC_W  = 8,
  parameter logic [OP_W-1:0] HEAD   = usub_pkg::USUB_HEAD_WORD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_i,
  input  logic              hi_step_i,
  input  logic              ovm_i,
  input  logic              rpt_pending_i,
  input  logic [OP_W-1:0]   op_word0_i,
  input  logic [OP_W-1:0]   op_word1_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] p_o,
  output logic              z_o,
  output logic              n_o,
  output logic              c_o,
  output logic              v_o,
  output logic [CNT_W-1:0]  ovcu_o,
  output logic              rpt_clear_o,
  output logic [LOC_W-1:0]  loc_o
);
  import usub_pkg::*;

  localparam int MSB = DATA_W - 1;

  logic              hit;
  logic [LOC_W-1:0]  loc_field;
  logic              commit;
  logic              bin;
  logic [DATA_W-1:0] diff;
  logic              borrow;
  logic              sovf;
  usub_flags_t       flags_q;
  usub_flags_t       flags_d;

  usub_decode #(.OP_W(OP_W), .LOC_W(LOC_W), .HEAD(HEAD)) u_decode (
    .word0_i (op_word0_i),
    .word1_i (op_word1_i),
    .hit_o   (hit),
    .loc_o   (loc_field)
  );

  always_comb begin
    commit = exec_i && (hit || hi_step_i);
    bin    = hi_step_i && !flags_q.c;
  end

  usub_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i      (reg_i),
    .b_i      (operand_i),
    .bin_i    (bin),
    .diff_o   (diff),
    .borrow_o (borrow),
    .sovf_o   (sovf)
  );

  usub_ovcu #(.CNT_W(CNT_W)) u_ovcu (
    .clk   (clk),
    .rst   (rst),
    .dec_i (commit && borrow),
    .ovm_i (ovm_i),
    .cnt_o (ovcu_o)
  );

  always_comb begin
    flags_d.z = (diff == '0);
    flags_d.n = diff[MSB];
    flags_d.c = !borrow;
    flags_d.v = flags_q.v || sovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_o         <= '0;
      flags_q     <= '0;
      rpt_clear_o <= 1'b0;
      loc_o       <= '0;
    end else begin
      rpt_clear_o <= commit && rpt_pending_i;
      if (commit) begin
        p_o     <= diff;
        flags_q <= flags_d;
      end
      if (exec_i && hit && !hi_step_i) loc_o <= loc_field;
    end
  end

  always_comb begin
    z_o = flags_q.z;
    n_o = flags_q.n;
    c_o = flags_q.c;
    v_o = flags_q.v;
  end

  p_zero_r2: assert property (@(posedge clk) disable iff (rst)
    commit |=> (z_o == (p_o == '0)));

  p_neg_r3: assert property (@(posedge clk) disable iff (rst)
    commit |=> (n_o == p_o[MSB]));

  p_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (commit && !hi_step_i) |=> (c_o == ($past(reg_i) >= $past(operand_i))));

  p_sticky_v_r5: assert property (@(posedge clk) disable iff (rst)
    v_o |=> v_o);

  p_rpt_clear_r7: assert property (@(posedge clk) disable iff (rst)
    rpt_clear_o |-> ($past(exec_i) && $past(rpt_pending_i)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !exec_i |=> ($stable(p_o) && $stable(ovcu_o) && $stable(loc_o)));
endmodule

// File: tb/usub_flag_unit_tb.sv
`timescale 1ns/100ps
module usub_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_i = 1'b0;
  logic        hi_step_i = 1'b0;
  logic        ovm_i = 1'b0;
  logic        rpt_pending_i = 1'b0;
  logic [15:0] op_word0_i = '0;
  logic [15:0] op_word1_i = '0;
  logic [31:0] reg_i = '0;
  logic [31:0] operand_i = '0;
  logic [31:0] p_o;
  logic        z_o, n_o, c_o, v_o;
  logic [5:0]  ovcu_o;
  logic        rpt_clear_o;
  logic [7:0]  loc_o;

  usub_flag_unit u_dut (
    .clk(clk), .rst(rst), .exec_i(exec_i), .hi_step_i(hi_step_i),
    .ovm_i(ovm_i), .rpt_pending_i(rpt_pending_i),
    .op_word0_i(op_word0_i), .op_word1_i(op_word1_i),
    .reg_i(reg_i), .operand_i(operand_i),
    .p_o(p_o), .z_o(z_o), .n_o(n_o), .c_o(c_o), .v_o(v_o),
    .ovcu_o(ovcu_o), .rpt_clear_o(rpt_clear_o), .loc_o(loc_o)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] p;
    logic        z, n, c, v;
    logic [5:0]  cnt;
    logic        rc;
    logic [7:0]  loc;
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  logic [31:0] m_p = '0;
  logic        m_z = 0, m_n = 0, m_c = 0, m_v = 0;
  logic [5:0]  m_cnt = '0;
  logic [7:0]  m_loc = '0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t snap(input logic rc, input string req);
    exp_t e;
    e.p = m_p; e.z = m_z; e.n = m_n; e.c = m_c; e.v = m_v;
    e.cnt = m_cnt; e.rc = rc; e.loc = m_loc; e.req = req;
    return e;
  endfunction

  // driver: R1 R2 R3 R4 R5 R6 R7 R8 R9 model
  task automatic do_op(input logic [15:0] w0, input logic [15:0] w1,
                       input logic hi, input logic ovm, input logic rpt,
                       input logic [31:0] a, input logic [31:0] b,
                       input string req);
    logic        hit, commit, bin, brw;
    logic [32:0] wide;
    hit    = (w0 == 16'h565D) && (w1[15:8] == 8'h00);
    commit = hit || hi;
    bin    = hi && !m_c;
    wide   = {1'b0, a} - {1'b0, b} - {32'b0, bin};
    brw    = wide[32];
    if (commit) begin
      if ((a[31] != b[31]) && (wide[31] != a[31])) m_v = 1'b1;
      m_p = wide[31:0];
      m_z = (wide[31:0] == 32'h0);
      m_n = wide[31];
      m_c = !brw;
      if (brw) m_cnt = m_cnt - 6'd1;
    end
    if (hit && !hi) m_loc = w1[7:0];
    @(negedge clk);
    op_word0_i = w0; op_word1_i = w1; hi_step_i = hi; ovm_i = ovm;
    rpt_pending_i = rpt; reg_i = a; operand_i = b; exec_i = 1'b1;
    @(posedge clk);
    #1;
    q.push_back(snap(commit && rpt, req));
    @(negedge clk);
    exec_i = 1'b0; rpt_pending_i = 1'b0; hi_step_i = 1'b0;
  endtask

  task automatic do_idle(input string req);
    @(negedge clk);
    exec_i = 1'b0;
    reg_i = 32'hDEAD_BEEF; operand_i = 32'h1234_5678;
    @(posedge clk);
    #1;
    q.push_back(snap(1'b0, req));
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "p",    p_o,                  e.p);
        check(e.req, "z",    {31'b0, z_o},         {31'b0, e.z});
        check(e.req, "n",    {31'b0, n_o},         {31'b0, e.n});
        check(e.req, "c",    {31'b0, c_o},         {31'b0, e.c});
        check(e.req, "v",    {31'b0, v_o},         {31'b0, e.v});
        check(e.req, "cnt",  {26'b0, ovcu_o},      {26'b0, e.cnt});
        check(e.req, "rclr", {31'b0, rpt_clear_o}, {31'b0, e.rc});
        check(e.req, "loc",  {24'b0, loc_o},       {24'b0, e.loc});
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [15:0] HD = 16'h565D;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    q.push_back(snap(1'b0, "R10"));           // R10 reset state
    do_op(HD, 16'h0011, 0, 0, 0, 32'd5, 32'd3, "R1");
    do_op(HD, 16'h0022, 0, 0, 0, 32'd3, 32'd5, "R4_R6");      // borrow, wrap to 63
    do_op(HD, 16'h0033, 0, 0, 0, 32'd7, 32'd7, "R2");
    do_op(HD, 16'h0044, 0, 0, 0, 32'h8000_0000, 32'd1, "R5"); // signed overflow
    do_op(HD, 16'h0055, 0, 0, 0, 32'd10, 32'd4, "R5_sticky");
    do_op(HD, 16'h0066, 0, 1, 0, 32'd1, 32'd2, "R6_ovm");
    do_op(HD, 16'h0077, 0, 0, 1, 32'd100, 32'd1, "R7");
    do_op(HD, 16'h0078, 0, 0, 0, 32'd9, 32'd2, "R7_noclr");
    do_idle("R11");
    do_op(16'h565C, 16'h0099, 0, 0, 1, 32'd50, 32'd1, "R8_head");
    do_op(HD, 16'h0199, 0, 0, 0, 32'd50, 32'd1, "R8_pad");
    do_op(HD, 16'h00A0, 0, 0, 0, 32'h0, 32'h1, "R9_low");
    do_op(16'h0000, 16'h0000, 1, 0, 0, 32'd5, 32'd2, "R9_hi");
    do_op(HD, 16'h00B0, 0, 0, 0, 32'h0000_FFFF, 32'h1, "R9_low2");
    do_op(16'h0000, 16'h0000, 1, 0, 0, 32'd3, 32'd3, "R9_hi2");
    do_op(HD, 16'h00C0, 0, 0, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R3");
    do_idle("R11_hold");
    for (int i = 0; i < 3; i++)
      do_op(HD, 16'h00D0, 0, i[0], 0, 32'd0, 32'd4, "R6_repeat");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule